// File: doc/BRIEF.md
# Comparator Change-Detect Interrupt

This block turns the digital output of an analog comparator into a maskable interrupt. It does not look for edges. It keeps a snapshot of the comparator output and compares the live output against that snapshot on every clock. The snapshot changes only when the CPU reads or writes the comparator control/status register. While the live output and the snapshot disagree, the change flag is set again on every cycle. To clear an interrupt, software first accesses the control/status register, which ends the mismatch, and then clears the flag.

Software reaches the block over a simple register bus with an address, a read strobe, a write strobe, write data and combinational read data. There are four registers:

- The control/status register reports the live comparator output.
- The flag register holds the change flag. Software can clear the flag there, or set it to simulate an interrupt.
- A local enable register.
- An interrupt control register, which holds the peripheral enable and the global enable.

The interrupt request is the flag qualified by all three enables. The comparator output must already be synchronous to the clock.

Top module: `cmp_change_irq`

## Requirements
- R1: Reset state. While `rst_n` is low, the flag, the snapshot and all three enables are 0, and `irq` is 0.
- R2: If the live output differs from the snapshot in a cycle with no control/status access, the flag is 1 after that clock edge.
- R3: A read of the control/status address returns the live comparator output in bit 6. All other bits of that read are 0.
- R4: Any read or write of the control/status address copies the live output into the snapshot. Once the flag has then been cleared, it stays 0 while the output holds its value.
- R5: While a mismatch persists, clearing the flag lasts one cycle only. The flag is 1 again after the next edge with no software write to it.
- R6: A write to the flag address loads bit 3 of the write data into the flag. Writing 1 gives a simulated interrupt. The other data bits have no effect.
- R7: A software write to the flag takes priority over a hardware set in the same cycle.
- R8: `irq` is 1 exactly when all four of these are 1:
  - the flag;
  - the local enable (bit 3 of the enable register);
  - the peripheral enable (bit 6 of the interrupt control register);
  - the global enable (bit 7 of the interrupt control register).
- R9: The flag is still set on a mismatch when any of the enables is 0.
- R10: If the output changes in the same cycle as a control/status access, the snapshot takes the new value and the flag is not set.
- R11: Register readback follows these rules:
  - the enable register reads back only bit 3;
  - the interrupt control register reads back only bits 7 and 6;
  - the flag register reads back only bit 3;
  - an unselected address, or a cycle with no read strobe, returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_out | input | 1 | Synchronized comparator output |
| bus_addr | input | AW | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Combinational read data |
| irq | output | 1 | Interrupt request |

## Verification
Two events can land on the same clock edge: a software write to the flag and a hardware mismatch set, and an output change and a control/status access. The bench provokes the first by writing 0 to the flag while the output disagrees with the snapshot. The flag must read 0 after that edge, then become 1 again on the following idle edge. It provokes the second by toggling `cmp_out` in the very cycle that the control register is read or written. The flag must stay 0 after that edge and on later idle edges, which shows the snapshot caught the new value. Random traffic mixes both collisions and is judged cycle by cycle against a bench model of the registers.

// File: rtl/cmp_irq_pkg.sv
package cmp_irq_pkg;

    // Bit positions that software decodes
    localparam int unsigned CTL_OUT_BIT = 6;
    localparam int unsigned FLAG_BIT    = 3;
    localparam int unsigned LOC_EN_BIT  = 3;
    localparam int unsigned PERIPH_BIT  = 6;
    localparam int unsigned GLOBAL_BIT  = 7;

    typedef struct packed {
        logic snap;
    } snap_state_t;

    typedef struct packed {
        logic flag;
    } flag_state_t;

    typedef struct packed {
        logic loc_en;
        logic periph_en;
        logic glob_en;
    } en_state_t;

endpackage

// File: rtl/cmp_snapshot.sv
module cmp_snapshot
    import cmp_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmp_out,
    input  logic refresh,
    output logic mismatch
);
    snap_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (refresh) begin
            st_d.snap = cmp_out;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mismatch = cmp_out != st_q.snap;

    // R4: an access captures the live output
    p_snap_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |=> st_q.snap == $past(cmp_out));

    // R4: without an access the snapshot holds its value
    p_snap_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !refresh |=> $stable(st_q.snap));

endmodule

// File: rtl/cmp_flag.sv
module cmp_flag
    import cmp_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hw_set,
    input  logic sw_wr,
    input  logic sw_val,
    output logic flag
);
    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sw_wr) begin
            st_d.flag = sw_val;
        end else if (hw_set) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;

    // R2: a hardware set with no software write leaves the flag set
    p_hw_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hw_set && !sw_wr |=> flag);

    // R7: a software write wins over a hardware set in the same cycle
    p_sw_priority_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr |=> flag == $past(sw_val));

    // R4: with no set and no write, the flag is stable
    p_flag_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_wr && !hw_set |=> $stable(flag));

endmodule

// File: rtl/cmp_irq_enables.sv
module cmp_irq_enables
    import cmp_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_local,
    input  logic wr_ctrl,
    input  logic wd_local,
    input  logic wd_periph,
    input  logic wd_global,
    output logic loc_en,
    output logic periph_en,
    output logic glob_en
);
    en_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_local) begin
            st_d.loc_en = wd_local;
        end
        if (wr_ctrl) begin
            st_d.periph_en = wd_periph;
            st_d.glob_en   = wd_global;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign loc_en    = st_q.loc_en;
    assign periph_en = st_q.periph_en;
    assign glob_en   = st_q.glob_en;

    // R11: an enable register loads its bits on a write
    p_ctrl_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> glob_en == $past(wd_global) && periph_en == $past(wd_periph));

endmodule

// File: rtl/cmp_change_irq.sv
module cmp_change_irq
    import cmp_irq_pkg::*;
#(
    parameter int unsigned AW       = 8,
    parameter int unsigned DW       = 8,
    parameter logic [AW-1:0] A_CTL  = 8'h20,
    parameter logic [AW-1:0] A_FLAG = 8'h21,
    parameter logic [AW-1:0] A_LEN  = 8'h22,
    parameter logic [AW-1:0] A_ICTL = 8'h23
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmp_out,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_rd,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq
);
    logic sel_ctl, sel_flag, sel_len, sel_ictl;
    logic ctl_access, mismatch, hw_set, flag;
    logic loc_en, periph_en, glob_en;
    logic unused_wdata;

    assign sel_ctl    = bus_addr == A_CTL;
    assign sel_flag   = bus_addr == A_FLAG;
    assign sel_len    = bus_addr == A_LEN;
    assign sel_ictl   = bus_addr == A_ICTL;
    assign ctl_access = sel_ctl && (bus_rd || bus_wr);
    assign unused_wdata = ^bus_wdata;

    cmp_snapshot u_snap (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmp_out  (cmp_out),
        .refresh  (ctl_access),
        .mismatch (mismatch)
    );

    // An access that refreshes the snapshot hides a change in that cycle
    assign hw_set = mismatch && !ctl_access;

    cmp_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .hw_set (hw_set),
        .sw_wr  (bus_wr && sel_flag),
        .sw_val (bus_wdata[FLAG_BIT]),
        .flag   (flag)
    );

    cmp_irq_enables u_en (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_local  (bus_wr && sel_len),
        .wr_ctrl   (bus_wr && sel_ictl),
        .wd_local  (bus_wdata[LOC_EN_BIT]),
        .wd_periph (bus_wdata[PERIPH_BIT]),
        .wd_global (bus_wdata[GLOBAL_BIT]),
        .loc_en    (loc_en),
        .periph_en (periph_en),
        .glob_en   (glob_en)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (sel_ctl) begin
                bus_rdata[CTL_OUT_BIT] = cmp_out;
            end else if (sel_flag) begin
                bus_rdata[FLAG_BIT] = flag;
            end else if (sel_len) begin
                bus_rdata[LOC_EN_BIT] = loc_en;
            end else if (sel_ictl) begin
                bus_rdata[PERIPH_BIT] = periph_en;
                bus_rdata[GLOBAL_BIT] = glob_en;
            end
        end
    end

    assign irq = flag && loc_en && periph_en && glob_en;

    // R8: a request needs the flag and the global enable
    p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag && glob_en);

    // R10: a control access with no flag write leaves the flag unchanged
    p_access_no_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_access && !(bus_wr && sel_flag) |=> flag == $past(flag));

    // R3: the control read shows the live output
    p_ctl_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && sel_ctl |-> bus_rdata[CTL_OUT_BIT] == cmp_out);

    // R1: no request while held in reset
    always_comb begin
        if (!rst_n) begin
            p_reset_quiet_r1: assert (!irq);
        end
    end

endmodule

// File: tb/test_cmp_change_irq.sv
`timescale 1ns/100ps
module test_cmp_change_irq;
    localparam logic [7:0] A_CTL  = 8'h20;
    localparam logic [7:0] A_FLAG = 8'h21;
    localparam logic [7:0] A_LEN  = 8'h22;
    localparam logic [7:0] A_ICTL = 8'h23;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmp_out = 1'b0;
    logic [7:0] bus_addr = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;

    int checks = 0;
    int fails = 0;

    // bench model of the register state
    logic m_snap = 1'b0, m_flag = 1'b0, m_len = 1'b0, m_pe = 1'b0, m_ge = 1'b0;

    always #2 clk = ~clk;

    cmp_change_irq i_cmp_change_irq (
        .clk(clk), .rst_n(rst_n), .cmp_out(cmp_out), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        logic [7:0] r;
        r = '0;
        if (a == A_CTL)       r[6] = cmp_out;
        else if (a == A_FLAG) r[3] = m_flag;
        else if (a == A_LEN)  r[3] = m_len;
        else if (a == A_ICTL) begin r[6] = m_pe; r[7] = m_ge; end
        return r;
    endfunction

    function automatic logic exp_irq();
        return m_flag & m_len & m_pe & m_ge;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // advance one clock with the current drive, updating the model
    task automatic tick();
        logic acc, set;
        acc = (bus_rd || bus_wr) && bus_addr == A_CTL;
        set = (cmp_out != m_snap) && !acc;
        if (bus_wr && bus_addr == A_FLAG) m_flag = bus_wdata[3];
        else if (set) m_flag = 1'b1;
        if (acc) m_snap = cmp_out;
        if (bus_wr && bus_addr == A_LEN) m_len = bus_wdata[3];
        if (bus_wr && bus_addr == A_ICTL) begin m_pe = bus_wdata[6]; m_ge = bus_wdata[7]; end
        @(posedge clk);
        #1;
        bus_rd = 1'b0;
        bus_wr = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick();
    endtask

    task automatic rd(input logic [7:0] a, input string req);
        bus_addr = a; bus_rd = 1'b1;
        #0.5;
        chk(req, bus_rdata, exp_read(a));
        tick();
    endtask

    // look at a register without letting a clock edge see the strobe
    task automatic peek(input logic [7:0] a, output logic [7:0] v);
        bus_addr = a; bus_rd = 1'b1;
        #0.5;
        v = bus_rdata;
        bus_rd = 1'b0;
        #0.5;
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] v;
        // R1: reset state
        #3;
        chk("R1 irq in reset", {7'd0, irq}, 8'h00);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(posedge clk); #1;
        peek(A_FLAG, v); chk("R1 flag", v, 8'h00);
        peek(A_LEN, v);  chk("R1 local enable", v, 8'h00);
        @(posedge clk); #1;
        peek(A_ICTL, v); chk("R1 ctrl enables", v, 8'h00);
        peek(8'h5A, v);  chk("R11 unselected addr", v, 8'h00);
        @(posedge clk); #1;
        chk("R11 no strobe gives 0", bus_rdata, 8'h00);

        // R11: enable readback masks
        wr(A_LEN, 8'hFF);
        wr(A_ICTL, 8'hFF);
        peek(A_LEN, v);  chk("R11 local enable readback", v, 8'h08);
        peek(A_ICTL, v); chk("R11 ctrl readback", v, 8'hC0);
        chk("R8 no flag no irq", {7'd0, irq}, 8'h00);

        // R2 / R8: mismatch sets flag and irq
        cmp_out = 1'b1;
        tick();
        peek(A_FLAG, v); chk("R2 flag set on mismatch", v, 8'h08);
        chk("R8 irq all enabled", {7'd0, irq}, 8'h01);

        // R7: clear while hardware sets in same cycle
        wr(A_FLAG, 8'h00);
        peek(A_FLAG, v); chk("R7 sw write wins", v, 8'h00);
        // R5: mismatch sets it again
        tick();
        peek(A_FLAG, v); chk("R5 flag re-set while mismatch persists", v, 8'h08);

        // R3 / R4: control read refreshes snapshot
        rd(A_CTL, "R3 ctl read shows output");
        wr(A_FLAG, 8'h00);
        tick();
        tick();
        peek(A_FLAG, v); chk("R4 flag stays clear after refresh", v, 8'h00);

        // R6: simulated interrupt and ignored bits
        wr(A_FLAG, 8'h08);
        chk("R6 simulated irq", {7'd0, irq}, 8'h01);
        wr(A_FLAG, 8'hF7);
        peek(A_FLAG, v); chk("R6 other bits ignored", v, 8'h00);

        // R9: set with enables off
        wr(A_LEN, 8'h00);
        cmp_out = 1'b0;
        tick();
        peek(A_FLAG, v); chk("R9 flag set with enable off", v, 8'h08);
        chk("R9 irq masked", {7'd0, irq}, 8'h00);
        wr(A_LEN, 8'h08);
        chk("R8 local enable restored", {7'd0, irq}, 8'h01);
        wr(A_ICTL, 8'h80);
        chk("R8 peripheral enable off", {7'd0, irq}, 8'h00);
        wr(A_ICTL, 8'h40);
        chk("R8 global enable off", {7'd0, irq}, 8'h00);
        wr(A_ICTL, 8'hC0);
        chk("R8 both enables on", {7'd0, irq}, 8'h01);

        // R10: change in the same cycle as a control access
        rd(A_CTL, "R3 ctl read low");
        wr(A_FLAG, 8'h00);
        cmp_out = 1'b1;
        rd(A_CTL, "R10 ctl read during change");
        peek(A_FLAG, v); chk("R10 no set on read collision", v, 8'h00);
        tick();
        peek(A_FLAG, v); chk("R10 snapshot took new value", v, 8'h00);
        cmp_out = 1'b0;
        wr(A_CTL, 8'hFF);
        tick();
        peek(A_FLAG, v); chk("R10 no set on write collision", v, 8'h00);
        chk("R4 write access refreshes", {7'd0, irq}, 8'h00);

        // random traffic against the model
        void'($urandom(32'h1234_5678));
        for (int i = 0; i < 2000; i++) begin
            int op;
            logic [7:0] a;
            if ($urandom_range(0, 3) == 0) cmp_out = ~cmp_out;
            op = $urandom_range(0, 5);
            case ($urandom_range(0, 4))
                0: a = A_CTL;
                1: a = A_FLAG;
                2: a = A_LEN;
                3: a = A_ICTL;
                default: a = 8'($urandom_range(0, 255));
            endcase
            if (op == 0)      rd(a, "R11 random read");
            else if (op == 1) wr(a, 8'($urandom_range(0, 255)));
            else              tick();
            chk("R8 random irq", {7'd0, irq}, {7'd0, exp_irq()});
            peek(A_FLAG, v);
            chk("R2 random flag", v, exp_read(A_FLAG));
        end

        summary();
        $finish;
    end
endmodule